// File: doc/BRIEF.md
# External Bus Idle Cycle Inserter

This block sits in an external bus controller between the CPU-side access request and the state sequencer that drives the external pins. It remembers the kind of the access now on the bus (read or write) and its address area. When the next access is chained directly behind it, the block decides whether one to four idle states must come first. The idle states give a slow device time to release the shared data bus before the next driver takes it. The chosen policy comes from a two-bit insertion mode and a two-bit gap length.

Requests arrive on a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and keep the request fields stable until that edge. `req_ready` is high only when the bus is idle or is in the last state of the current access. A chained request is therefore taken at the end of the current access, and the bus never stalls in the middle of a cycle. The mode and length inputs are plain control pins and are sampled on the acceptance edge.

Top module: `xbus_idle_gap`

## Requirements
- R1: After reset the bus is idle: `bus_state`=00, `idle_ins`=0, `addr_oe`, `rd_stb`, `wr_stb` and `data_oe` are 0, and `req_ready`=1.
- R2: A read runs through `bus_state` 01 (T1), 10 (T2), 11 (T3), with `rd_stb` high in T2 and T3. A write runs through 01, 10, with `data_oe` high in T1 and T2 and `wr_stb` high in T2. `addr_oe` is high and `bus_addr` carries the accepted address in every T state.
- R3: A read chained directly behind a read to a different area (`req_area`) gets idle states before its T1 when the mode is 01, 10 or 11.
- R4: A write chained directly behind a read gets idle states when the mode is 10 or 11, and none when the mode is 01.
- R5: With mode 00 no idle state is ever inserted.
- R6: A read behind a read to the same area, and any access behind a write, gets no idle state.
- R7: An access accepted while the bus is idle (first access after reset, or after at least one idle cycle) gets no idle state.
- R8: The gap length selects the idle-state count: 00→1, 01→2, 10→3, 11→4.
- R9: During an inserted idle state `idle_ins`=1 and `bus_state`=00, while `addr_oe`, `rd_stb`, `wr_stb` and `data_oe` are all 0. The next state is T1 of the new access.
- R10: `req_ready` is 0 in T1, in the idle states and in the non-final T states. It is 1 in the final state (T3 of a read, T2 of a write) and while the bus is idle.
- R11: Mode and gap length are sampled on the acceptance edge. A change after that edge does not alter the gap of the access already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_mode | input | 2 | Insertion mode: 00 off, 01 read-read only, 1x read-read and read-write |
| idle_len | input | 2 | Gap length code, count = code + 1 |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_area | input | AREA_W (3) | Address area number of the request |
| req_addr | input | ADDR_W (16) | Address of the request |
| bus_state | output | 2 | 00 idle/Ti, 01 T1, 10 T2, 11 T3 |
| idle_ins | output | 1 | High during each inserted idle state |
| bus_addr | output | ADDR_W (16) | Address of the access on the bus |
| addr_oe | output | 1 | Address bus driven |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| data_oe | output | 1 | Data bus driven by this side (writes) |

## Verification
The hardest case to reach is a request that must be taken in exactly the final state of the access before it. Only then does the pairing rule apply. One cycle too late, the bus is idle and the gap is skipped by design. Each scenario task therefore presents the second request while the first is still in T1 and holds it until `req_ready` rises. The same tasks also run a variant that waits for a real idle cycle, and a variant that flips mode and length right after acceptance.

// File: rtl/xbus_gap_pkg.sv
package xbus_gap_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_TI   = 3'd1,
    SQ_T1   = 3'd2,
    SQ_T2   = 3'd3,
    SQ_T3   = 3'd4
  } seq_t;

  localparam logic [1:0] PIN_IDLE = 2'b00;
  localparam logic [1:0] PIN_T1   = 2'b01;
  localparam logic [1:0] PIN_T2   = 2'b10;
  localparam logic [1:0] PIN_T3   = 2'b11;
endpackage

// File: rtl/xbus_gap_policy.sv
module xbus_gap_policy #(
  parameter int AREA_W = 3
) (
  input  logic              chained,
  input  logic              prev_write,
  input  logic [AREA_W-1:0] prev_area,
  input  logic              next_write,
  input  logic [AREA_W-1:0] next_area,
  input  logic [1:0]        mode,
  output logic              need_gap
);
  logic rr_hit;
  logic rw_hit;

  always_comb begin
    rr_hit   = !next_write && (next_area != prev_area) && (mode != 2'b00);
    rw_hit   = next_write && mode[1];
    need_gap = chained && !prev_write && (rr_hit || rw_hit);
  end
endmodule

// File: rtl/xbus_gap_timer.sv
module xbus_gap_timer #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             count,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (count && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count && !load && last) |=> last); // R8
endmodule

// File: rtl/xbus_idle_gap.sv
module xbus_idle_gap
  import xbus_gap_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        idle_mode,
  input  logic [LEN_W-1:0]  idle_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        bus_state,
  output logic              idle_ins,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_oe,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              data_oe
);
  seq_t              st_q, st_d;
  logic              cur_wr_q;
  logic [AREA_W-1:0] cur_area_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic              at_end;
  logic              take;
  logic              need_gap;
  logic              gap_last;

  assign at_end    = (st_q == SQ_T3) || (st_q == SQ_T2 && cur_wr_q);
  assign req_ready = (st_q == SQ_IDLE) || at_end;
  assign take      = req_valid && req_ready;

  xbus_gap_policy #(.AREA_W(AREA_W)) u_policy (
    .chained   (at_end),
    .prev_write(cur_wr_q),
    .prev_area (cur_area_q),
    .next_write(req_write),
    .next_area (req_area),
    .mode      (idle_mode),
    .need_gap  (need_gap)
  );

  xbus_gap_timer #(.LEN_W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take && need_gap),
    .load_val(idle_len),
    .count   (st_q == SQ_TI),
    .last    (gap_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_TI:   st_d = gap_last ? SQ_T1 : SQ_TI;
      SQ_T1:   st_d = SQ_T2;
      SQ_T2:   st_d = cur_wr_q ? SQ_IDLE : SQ_T3;
      SQ_T3:   st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
    if (take) st_d = need_gap ? SQ_TI : SQ_T1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      cur_wr_q   <= 1'b1;
      cur_area_q <= '0;
      cur_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        cur_wr_q   <= req_write;
        cur_area_q <= req_area;
        cur_addr_q <= req_addr;
      end
    end
  end

  always_comb begin
    bus_state = PIN_IDLE;
    case (st_q)
      SQ_T1:   bus_state = PIN_T1;
      SQ_T2:   bus_state = PIN_T2;
      SQ_T3:   bus_state = PIN_T3;
      default: bus_state = PIN_IDLE;
    endcase
  end

  assign idle_ins = (st_q == SQ_TI);
  assign addr_oe  = (st_q == SQ_T1) || (st_q == SQ_T2) || (st_q == SQ_T3);
  assign bus_addr = cur_addr_q;
  assign rd_stb   = !cur_wr_q && ((st_q == SQ_T2) || (st_q == SQ_T3));
  assign wr_stb   = cur_wr_q && (st_q == SQ_T2);
  assign data_oe  = cur_wr_q && ((st_q == SQ_T1) || (st_q == SQ_T2));

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ins |-> (!addr_oe && !rd_stb && !wr_stb && !data_oe && bus_state == PIN_IDLE)); // R9
  AST_READ_HAS_T3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == PIN_T2 && rd_stb && !take) |=> (bus_state == PIN_T3)); // R2
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st_q == SQ_IDLE) |=> (bus_state == PIN_T1)); // R7
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idle_mode == 2'b00) |=> !idle_ins); // R5
  AST_RW_MODE01: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_stb && req_write && idle_mode == 2'b01) |=> (bus_state == PIN_T1)); // R4
  AST_GAP_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ins && !$past(idle_ins)) |-> !req_ready); // R10
endmodule

// File: tb/xbus_idle_gap_bench.sv
module xbus_idle_gap_bench;
  localparam int CLK_NS = 10;
  localparam int AREA_W = 3;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        idle_mode = 2'b00;
  logic [1:0]        idle_len = 2'b00;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [AREA_W-1:0] req_area = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        bus_state;
  logic              idle_ins;
  logic [ADDR_W-1:0] bus_addr;
  logic              addr_oe, rd_stb, wr_stb, data_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  xbus_idle_gap u_xbus_idle_gap (
    .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .idle_len(idle_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_area(req_area), .req_addr(req_addr), .bus_state(bus_state),
    .idle_ins(idle_ins), .bus_addr(bus_addr), .addr_oe(addr_oe),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .data_oe(data_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_gap(bit a_wr, int a_ar, bit b_wr, int b_ar,
                                    logic [1:0] mode, logic [1:0] len, bit gap);
    if (gap || a_wr || mode == 2'b00) return 0;
    if (b_wr) return mode[1] ? int'(len) + 1 : 0;
    return (a_ar != b_ar) ? int'(len) + 1 : 0;
  endfunction

  task automatic drive_req(bit wr, int ar);
    req_valid = 1'b1;
    req_write = wr;
    req_area  = AREA_W'(ar);
    req_addr  = ADDR_W'(16'h1000 + ar * 16 + (wr ? 1 : 0));
  endtask

  // one access pair: A then B, chained or separated by an idle cycle
  task automatic run_pair(input string tag, input bit a_wr, input int a_ar,
                          input bit b_wr, input int b_ar, input logic [1:0] mode,
                          input logic [1:0] len, input bit gap, input bit flip);
    int exp_n;
    int ti;
    logic [ADDR_W-1:0] b_addr;
    exp_n = expect_gap(a_wr, a_ar, b_wr, b_ar, mode, len, gap);
    @(negedge clk);
    req_valid = 1'b0;
    idle_mode = mode;
    idle_len  = len;
    @(negedge clk);
    drive_req(a_wr, a_ar);
    @(negedge clk);
    check(bus_state == 2'b01 && req_ready == 1'b0, {tag, " R10 T1 not ready"},
          int'(req_ready), 0);
    if (gap) begin
      req_valid = 1'b0;
      for (int i = 0; i < 10 && (bus_state != 2'b00 || idle_ins); i++) @(negedge clk);
    end
    drive_req(b_wr, b_ar);
    b_addr = req_addr;
    for (int i = 0; i < 10 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin
      idle_mode = ~mode;
      idle_len  = ~len;
    end
    ti = 0;
    for (int i = 0; i < 10 && idle_ins; i++) begin
      check(!addr_oe && !rd_stb && !wr_stb && !data_oe && bus_state == 2'b00 && !req_ready,
            {tag, " R9 quiet gap"}, int'({addr_oe, rd_stb, wr_stb, data_oe}), 0);
      ti++;
      @(negedge clk);
    end
    check(ti == exp_n, {tag, " R3 R4 R5 R6 R7 R8 R11 gap count"}, ti, exp_n);
    check(bus_state == 2'b01 && addr_oe && bus_addr == b_addr, {tag, " R2 T1 addr"},
          int'(bus_addr), int'(b_addr));
    check(data_oe == b_wr && !rd_stb && !wr_stb, {tag, " R2 T1 strobes"},
          int'({data_oe, rd_stb, wr_stb}), b_wr ? 4 : 0);
    @(negedge clk);
    check(bus_state == 2'b10 && rd_stb == !b_wr && wr_stb == b_wr,
          {tag, " R2 T2"}, int'({bus_state, rd_stb, wr_stb}),
          int'({2'b10, !b_wr, b_wr}));
    if (!b_wr) begin
      @(negedge clk);
      check(bus_state == 2'b11 && rd_stb && req_ready, {tag, " R2 R10 T3"},
            int'(bus_state), 3);
    end else begin
      check(req_ready == 1'b1, {tag, " R10 write end ready"}, int'(req_ready), 1);
    end
    @(negedge clk);
    check(bus_state == 2'b00 && !addr_oe && req_ready, {tag, " R10 back idle"},
          int'(bus_state), 0);
    idle_mode = mode;
    idle_len  = len;
  endtask

  task automatic t_reset;
    check(bus_state == 2'b00 && !idle_ins && !addr_oe && !rd_stb && !wr_stb &&
          !data_oe && req_ready, "R1 reset state",
          int'({bus_state, idle_ins, addr_oe, rd_stb, wr_stb, data_oe, req_ready}), 1);
  endtask

  task automatic t_read_read;
    run_pair("rr diff m01 l00", 0, 1, 0, 2, 2'b01, 2'b00, 0, 0); // R3
    run_pair("rr diff m11 l11", 0, 3, 0, 5, 2'b11, 2'b11, 0, 0); // R3 R8
    run_pair("rr diff m10 l01", 0, 0, 0, 7, 2'b10, 2'b01, 0, 0); // R8
    run_pair("rr diff m01 l10", 0, 4, 0, 6, 2'b01, 2'b10, 0, 0); // R8
    run_pair("rr same m11",     0, 2, 0, 2, 2'b11, 2'b11, 0, 0); // R6
  endtask

  task automatic t_read_write;
    run_pair("rw m10 l01", 0, 1, 1, 1, 2'b10, 2'b01, 0, 0); // R4
    run_pair("rw m11 l00", 0, 1, 1, 3, 2'b11, 2'b00, 0, 0); // R4
    run_pair("rw m01",     0, 1, 1, 3, 2'b01, 2'b11, 0, 0); // R4
  endtask

  task automatic t_mode_off;
    run_pair("rr m00", 0, 1, 0, 2, 2'b00, 2'b11, 0, 0); // R5
    run_pair("rw m00", 0, 1, 1, 2, 2'b00, 2'b11, 0, 0); // R5
  endtask

  task automatic t_after_write;
    run_pair("wr m11", 1, 1, 0, 2, 2'b11, 2'b11, 0, 0); // R6
    run_pair("ww m11", 1, 1, 1, 2, 2'b11, 2'b11, 0, 0); // R6
  endtask

  task automatic t_idle_gap;
    run_pair("rr gap m11", 0, 1, 0, 2, 2'b11, 2'b11, 1, 0); // R7
  endtask

  task automatic t_late_change;
    run_pair("rr flip m01 l10", 0, 1, 0, 2, 2'b01, 2'b10, 0, 1); // R11
    run_pair("rw flip m10 l00", 0, 1, 1, 2, 2'b10, 2'b00, 0, 1); // R11
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 2 + 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_read();
    t_read_write();
    t_mode_off();
    t_after_write();
    t_idle_gap();
    t_late_change();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule